// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers many interrupt sources into a small set of prioritised outputs for a processor. Its 124 request strobes are organised as 31 groups of four lines each. Groups 0 and 1 are non-maskable: any strobe on them produces a single-cycle pulse on a dedicated output. Groups 2 to 30 are maskable. Each of them has four request bits, four enable bits and a 3-bit priority level, and they compete for a 3-bit level output on which a smaller number means more urgent and 7 means nothing is pending.

Software reaches each group through a 4-byte window on a byte-wide register bus. It reads pending and masked-pending bits, programs the level and the enables, and sets or clears individual request bits through a select/value nibble pair. When the processor takes an interrupt it raises an acknowledge together with the level it believes it is serving. The block then records the winning group in an accepted-group register, which software reads to find the source. A level on the acknowledge that does not match the current output sets a sticky error flag.

Top module: `grp_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on request line n sets request bit n%4 of group n/4. A request bit whose enable bit is 0 stays pending but does not take part in priority resolution.
- R2: For a maskable group, reading byte 0 of its window (bus address 4*g) returns the request bits in [7:4] and request AND enable in [3:0].
- R3: Writing byte 1 of a maskable group (address 4*g+1) loads the level from bits [6:4] and the enables from bits [3:0]. Reading it returns the same layout with bit 7 at 0. Bytes 2 and 3 of every window, addresses 0x7C to 0x7F, and all other unmapped addresses read as zero.
- R4: Writing byte 0 of a maskable group uses bits [3:0] as per-bit selects and bits [7:4] as per-bit values. A selected request bit takes its value bit, and an unselected bit keeps its state.
- R5: irq_level is the level of the enabled-and-pending maskable group with the numerically smallest level. On a tie the lower group number wins. A group at level 7 never wins. With no qualifying group, irq_level is 7. The output follows a control write or strobe from the next clock edge.
- R6: An ack latches the currently winning group number. A read of address 0x80 returns that number shifted left by 2, or 0 if the accepted group no longer has request AND enable nonzero. Address 0x81 reads 0, and writes to 0x80 and 0x81 change nothing.
- R7: An ack whose ack_level differs from irq_level sets ack_err, which stays set until reset. The selection is latched regardless.
- R8: For groups 0 and 1, byte 0 reads the request bits in [3:0], and writing 1s to bits [3:0] clears the matching bits. Any strobe on these groups gives a one-cycle nmi_pulse in the following cycle. These groups never affect irq_level.
- R9: After reset, all request bits, maskable enables and levels are 0, irq_level is 7, the accepted group is 0 and ack_err is 0.
- R10: A read presented in one cycle (bus_sel high, bus_wr low) returns its data on bus_rdata after the next clock edge. bus_rdata is 0 after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_set | input | 124 | Per-line request set strobes; line n maps to group n/4, bit n%4 |
| ack | input | 1 | Processor accepts the current maskable interrupt |
| ack_level | input | 3 | Level the processor believes it accepted |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_level | output | 3 | Winning maskable level, 7 = idle |
| nmi_pulse | output | 1 | One-cycle non-maskable request pulse |
| ack_err | output | 1 | Sticky acknowledge-level mismatch flag |

## Verification
Priority resolution is tried with four kinds of stimulus, each of which separates a different design error:
- Two groups at equal level: separates lowest-group-wins from last-group-wins.
- A later group moved to a strictly lower level: shows that level, not index, rules.
- A winner at level 7: shows that a strict comparison against the idle value is used.
- A pending line whose enable bit is off: shows that the unmasked request is not used in place of the masked one.

Byte-0 writes combine set, clear and no-select patterns, which separate select/value decoding from a plain overwrite. The accepted-group register is read both while its request is live and after that request is cleared, which tells the live check apart from a plain latch. NMI strobes are checked for pulse width and for their lack of effect on the level output.

// File: rtl/gic_pkg.sv
`timescale 1ns/1ps
package gic_pkg;
    localparam int NUM_GROUPS = 31;
    localparam int NMI_GROUPS = 2;
    localparam int LINES      = 4;
    localparam int LVL_W      = 3;
    localparam int ADDR_W     = 8;
    localparam logic [7:0] ACC_ADDR = 8'h80;
endpackage

// File: rtl/gic_group.sv
`timescale 1ns/1ps
module gic_group #(
    parameter bit IS_NMI = 1'b0,
    parameter int LINES  = 4,
    parameter int LVL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] set_i,
    input  logic             wr_req_i,
    input  logic             wr_cfg_i,
    input  logic [7:0]       wdata_i,
    output logic [LINES-1:0] req_o,
    output logic [LINES-1:0] en_o,
    output logic [LVL_W-1:0] lvl_o
);
    typedef struct packed {
        logic [LINES-1:0] req;
        logic [LINES-1:0] en;
        logic [LVL_W-1:0] lvl;
    } grp_t;

    grp_t grp_d, grp_q;
    logic [LINES-1:0] sel_bits, val_bits;

    always_comb begin
        sel_bits = wdata_i[LINES-1:0];
        val_bits = wdata_i[4 +: LINES];
        grp_d    = grp_q;
        if (wr_req_i) begin
            if (IS_NMI) grp_d.req = grp_q.req & ~sel_bits;
            else        grp_d.req = (grp_q.req & ~sel_bits) | (val_bits & sel_bits);
        end
        if (wr_cfg_i && !IS_NMI) begin
            grp_d.lvl = wdata_i[4 +: LVL_W];
            grp_d.en  = wdata_i[LINES-1:0];
        end
        // a strobe arriving with a write wins over a clear
        grp_d.req = grp_d.req | set_i;
        if (IS_NMI) grp_d.en = '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q.req <= '0;
            grp_q.en  <= IS_NMI ? '1 : '0;
            grp_q.lvl <= '0;
        end else begin
            grp_q <= grp_d;
        end
    end

    assign req_o = grp_q.req;
    assign en_o  = grp_q.en;
    assign lvl_o = grp_q.lvl;

    // R4: an empty select with no strobe leaves the request bits alone
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && wdata_i[LINES-1:0] == '0 && set_i == '0) |=> (req_o == $past(req_o)));

    // R1: a strobed line is pending after the edge
    assert_strobe_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((req_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/gic_prio_resolve.sv
`timescale 1ns/1ps
module gic_prio_resolve #(
    parameter int NUM_GROUPS = 31,
    parameter int NMI_GROUPS = 2,
    parameter int LINES      = 4,
    parameter int LVL_W      = 3,
    parameter int GID_W      = $clog2(NUM_GROUPS)
) (
    input  logic [NUM_GROUPS-1:0][LINES-1:0] req_i,
    input  logic [NUM_GROUPS-1:0][LINES-1:0] en_i,
    input  logic [NUM_GROUPS-1:0][LVL_W-1:0] lvl_i,
    output logic [GID_W-1:0]                 sel_gid_o,
    output logic [LVL_W-1:0]                 sel_lvl_o
);
    localparam logic [LVL_W-1:0] IDLE_LVL = '1;

    always_comb begin
        sel_gid_o = '0;
        sel_lvl_o = IDLE_LVL;
        for (int g = NMI_GROUPS; g < NUM_GROUPS; g++) begin
            if (((req_i[g] & en_i[g]) != '0) && (lvl_i[g] < sel_lvl_o)) begin
                sel_gid_o = GID_W'(g);
                sel_lvl_o = lvl_i[g];
            end
        end
    end
endmodule

// File: rtl/grp_irq_ctrl.sv
`timescale 1ns/1ps
module grp_irq_ctrl #(
    parameter int NUM_GROUPS = gic_pkg::NUM_GROUPS,
    parameter int NMI_GROUPS = gic_pkg::NMI_GROUPS,
    parameter int LINES      = gic_pkg::LINES,
    parameter int LVL_W      = gic_pkg::LVL_W,
    parameter int ADDR_W     = gic_pkg::ADDR_W,
    parameter logic [7:0] ACC_ADDR = gic_pkg::ACC_ADDR
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS*LINES-1:0] req_set,
    input  logic                        ack,
    input  logic [LVL_W-1:0]            ack_level,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [7:0]                  bus_wdata,
    output logic [7:0]                  bus_rdata,
    output logic [LVL_W-1:0]            irq_level,
    output logic                        nmi_pulse,
    output logic                        ack_err
);
    localparam int GID_W     = $clog2(NUM_GROUPS);
    localparam int ICR_BYTES = NUM_GROUPS * 4;
    localparam int NMI_LINES = NMI_GROUPS * LINES;
    localparam logic [LVL_W-1:0] IDLE_LVL = '1;

    typedef struct packed {
        logic [GID_W-1:0] acc;
        logic             err;
        logic             nmi;
        logic [7:0]       rdata;
    } ctl_t;

    ctl_t st_d, st_q;

    logic                            rd_en, wr_en, in_icr;
    logic [ADDR_W-3:0]               gid_a;
    logic [1:0]                      byte_a;
    logic [NUM_GROUPS-1:0]           wr_req, wr_cfg, act;
    logic [NUM_GROUPS-1:0][LINES-1:0] req_all, en_all;
    logic [NUM_GROUPS-1:0][LVL_W-1:0] lvl_all;
    logic [GID_W-1:0]                sel_gid;
    logic [LVL_W-1:0]                sel_lvl;
    logic [7:0]                      rd_val;
    logic                            acc_live;

    always_comb begin
        rd_en  = bus_sel && !bus_wr;
        wr_en  = bus_sel && bus_wr;
        in_icr = int'(bus_addr) < ICR_BYTES;
        gid_a  = bus_addr[ADDR_W-1:2];
        byte_a = bus_addr[1:0];
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign wr_req[g] = wr_en && in_icr && (int'(gid_a) == g) && (byte_a == 2'd0);
        assign wr_cfg[g] = wr_en && in_icr && (int'(gid_a) == g) && (byte_a == 2'd1);

        gic_group #(
            .IS_NMI (g < NMI_GROUPS),
            .LINES  (LINES),
            .LVL_W  (LVL_W)
        ) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (req_set[g*LINES +: LINES]),
            .wr_req_i (wr_req[g]),
            .wr_cfg_i (wr_cfg[g]),
            .wdata_i  (bus_wdata),
            .req_o    (req_all[g]),
            .en_o     (en_all[g]),
            .lvl_o    (lvl_all[g])
        );

        assign act[g] = (req_all[g] & en_all[g]) != '0;
    end

    gic_prio_resolve #(
        .NUM_GROUPS (NUM_GROUPS),
        .NMI_GROUPS (NMI_GROUPS),
        .LINES      (LINES),
        .LVL_W      (LVL_W),
        .GID_W      (GID_W)
    ) u_resolve (
        .req_i     (req_all),
        .en_i      (en_all),
        .lvl_i     (lvl_all),
        .sel_gid_o (sel_gid),
        .sel_lvl_o (sel_lvl)
    );

    always_comb begin
        acc_live = 1'b0;
        rd_val   = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (int'(st_q.acc) == g) acc_live = act[g];
            if (in_icr && int'(gid_a) == g) begin
                if (byte_a == 2'd0) begin
                    if (g < NMI_GROUPS) rd_val = 8'(req_all[g]);
                    else                rd_val = 8'({req_all[g], req_all[g] & en_all[g]});
                end else if (byte_a == 2'd1 && g >= NMI_GROUPS) begin
                    rd_val = 8'({1'b0, lvl_all[g], en_all[g]});
                end
            end
        end
        if (bus_addr == ACC_ADDR && acc_live) rd_val = 8'({st_q.acc, 2'b00});

        st_d       = st_q;
        st_d.nmi   = |req_set[NMI_LINES-1:0];
        st_d.rdata = rd_en ? rd_val : '0;
        if (ack) begin
            st_d.acc = sel_gid;
            if (ack_level != sel_lvl) st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign irq_level = sel_lvl;
    assign nmi_pulse = st_q.nmi;
    assign ack_err   = st_q.err;

    // R5: a non-idle level always names a group that is pending and enabled
    assert_pick_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != IDLE_LVL) |-> (act[sel_gid] && int'(sel_gid) >= NMI_GROUPS));

    // R8: a pulse only follows a strobe on a non-maskable line
    assert_nmi_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |-> $past(|req_set[NMI_LINES-1:0]));

    // R7: the error flag never drops while out of reset
    assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |=> ack_err);

    // R7: the flag rises only after a mismatched acknowledge
    assert_err_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_err) |-> $past(ack && ack_level != irq_level));

    // R10: no read presented means zero data after the edge
    assert_rd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> (bus_rdata == 8'h00));
endmodule

// File: tb/grp_irq_ctrl_test.sv
`timescale 1ns/1ps
module grp_irq_ctrl_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [123:0] req_set = '0;
    logic         ack = 1'b0;
    logic [2:0]   ack_level = '0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic [2:0]   irq_level;
    logic         nmi_pulse;
    logic         ack_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    grp_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .ack(ack), .ack_level(ack_level),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_level(irq_level), .nmi_pulse(nmi_pulse), .ack_err(ack_err)
    );

    // {kind, addr_or_line, data, expected, req}
    // kind 0: write, expect irq_level; 1: read, expect rdata; 2: strobe line, expect irq_level
    localparam int NV = 23;
    localparam logic [29:0] VEC [NV] = '{
        {2'd0, 8'h09, 8'h5F, 8'h07, 4'd3},  // R3 g2 level 5, enables all
        {2'd2, 8'd8,  8'h00, 8'h05, 4'd1},  // R1 line 8 -> g2 bit0
        {2'd1, 8'h08, 8'h00, 8'h11, 4'd2},  // R2
        {2'd1, 8'h09, 8'h00, 8'h5F, 4'd3},  // R3
        {2'd0, 8'h0D, 8'h53, 8'h05, 4'd3},  // R3 g3 level 5, en 0011
        {2'd2, 8'd13, 8'h00, 8'h05, 4'd5},  // R5 tie -> lower group
        {2'd0, 8'h0D, 8'h33, 8'h03, 4'd5},  // R5 lower level wins
        {2'd1, 8'h0C, 8'h00, 8'h22, 4'd2},  // R2
        {2'd0, 8'h0C, 8'h02, 8'h05, 4'd4},  // R4 select bit1, value 0
        {2'd1, 8'h0C, 8'h00, 8'h00, 4'd4},  // R4
        {2'd0, 8'h08, 8'hE0, 8'h05, 4'd4},  // R4 no select
        {2'd1, 8'h08, 8'h00, 8'h11, 4'd4},  // R4
        {2'd0, 8'h08, 8'h44, 8'h05, 4'd4},  // R4 select bit2, value 1
        {2'd1, 8'h08, 8'h00, 8'h55, 4'd4},  // R4
        {2'd0, 8'h09, 8'h50, 8'h07, 4'd5},  // R5 g2 masked -> idle
        {2'd1, 8'h08, 8'h00, 8'h50, 4'd2},  // R2 pending but masked
        {2'd1, 8'h0A, 8'h00, 8'h00, 4'd3},  // R3 byte 2
        {2'd1, 8'h7F, 8'h00, 8'h00, 4'd3},  // R3 beyond windows
        {2'd0, 8'h79, 8'h21, 8'h07, 4'd3},  // R3 g30 level 2, en bit0
        {2'd2, 8'd123,8'h00, 8'h07, 4'd1},  // R1 disabled line stays out
        {2'd2, 8'd120,8'h00, 8'h02, 4'd1},  // R1 g30 bit0
        {2'd0, 8'h79, 8'h71, 8'h07, 4'd5},  // R5 level 7 never wins
        {2'd1, 8'h78, 8'h00, 8'h91, 4'd1}   // R1 g30 holds bits 3 and 0
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic strobe(input int line);
        req_set[line] = 1'b1;
        @(negedge clk);
        req_set = '0;
    endtask

    task automatic do_ack(input logic [2:0] lv);
        ack = 1'b1; ack_level = lv;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R9 reset state
        chk("R9 irq_level", 8'(irq_level), 8'h07);
        chk("R9 nmi_pulse", 8'(nmi_pulse), 8'h00);
        chk("R9 ack_err", 8'(ack_err), 8'h00);
        bus_read(8'h80);
        chk("R9 accepted", bus_rdata, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] k;
            logic [7:0] a, d, e;
            logic [3:0] r;
            {k, a, d, e, r} = VEC[i];
            if (k == 2'd0) begin
                bus_write(a, d);
                chk($sformatf("R%0d vec%0d level", r, i), 8'(irq_level), e);
            end else if (k == 2'd1) begin
                bus_read(a);
                chk($sformatf("R%0d vec%0d rdata", r, i), bus_rdata, e);
            end else begin
                strobe(int'(a));
                chk($sformatf("R%0d vec%0d level", r, i), 8'(irq_level), e);
            end
        end

        // R10: data is gone one cycle after the read
        @(negedge clk);
        chk("R10 rdata idle", bus_rdata, 8'h00);

        // R6 acknowledge and accepted-group read
        bus_write(8'h09, 8'h4F);
        chk("R5 g2 level 4", 8'(irq_level), 8'h04);
        do_ack(3'd4);
        chk("R7 matched ack", 8'(ack_err), 8'h00);
        bus_read(8'h80);
        chk("R6 accepted g2", bus_rdata, 8'h08);
        bus_read(8'h81);
        chk("R6 byte1 zero", bus_rdata, 8'h00);
        bus_write(8'h80, 8'hFF);
        bus_read(8'h80);
        chk("R6 write ignored", bus_rdata, 8'h08);
        bus_write(8'h08, 8'h0F);
        chk("R4 clear all", 8'(irq_level), 8'h07);
        bus_read(8'h80);
        chk("R6 lost request", bus_rdata, 8'h00);

        // R7 mismatch sets sticky error
        do_ack(3'd3);
        chk("R7 mismatch", 8'(ack_err), 8'h01);
        repeat (3) @(negedge clk);
        chk("R7 sticky", 8'(ack_err), 8'h01);

        // R8 non-maskable groups
        strobe(2);
        chk("R8 pulse", 8'(nmi_pulse), 8'h01);
        chk("R8 level untouched", 8'(irq_level), 8'h07);
        @(negedge clk);
        chk("R8 one cycle", 8'(nmi_pulse), 8'h00);
        bus_read(8'h00);
        chk("R8 read g0", bus_rdata, 8'h04);
        bus_write(8'h00, 8'h04);
        bus_read(8'h00);
        chk("R8 clear g0", bus_rdata, 8'h00);
        strobe(5);
        chk("R8 pulse g1", 8'(nmi_pulse), 8'h01);
        bus_read(8'h04);
        chk("R8 read g1", bus_rdata, 8'h02);

        // R9 second reset clears everything
        do_reset();
        chk("R9 err cleared", 8'(ack_err), 8'h00);
        chk("R9 level idle", 8'(irq_level), 8'h07);
        bus_read(8'h78);
        chk("R9 request cleared", bus_rdata, 8'h00);
        bus_read(8'h79);
        chk("R9 config cleared", bus_rdata, 8'h00);

        finish_run();
    end
endmodule